// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Output Unpacker

This block sits on the read side of a wide long-word queue and feeds a narrower read port. The queue shows its head long word together with a valid flag. The block cuts that word into one, two or four transfers, depending on the selected port size. In word size it delivers two halves of 18 bits. In byte size it delivers four 9-bit lanes, each lane being 8 data bits plus one extra bit. In long size it passes the whole 36-bit word in a single transfer.

The order of the pieces is fixed once, when the block leaves reset. The level of the order-select pin at the first clock edge after the main reset is released picks big-endian order or little-endian order. Big-endian delivers the most significant piece first. Little-endian delivers the least significant piece first. After that clock edge the pin has no effect. The block pulses a pop back to the queue only when the last piece of the head word is taken.

A synchronous partial reset rewinds the piece position to the first piece and keeps the latched order.

Top module: `bus_unpacker`

## Requirements
- R1: The level of `order_sel_i` at the first rising clock edge after `rst_ni` goes high selects the order: 1 selects big-endian and 0 selects little-endian. Changes of `order_sel_i` after that edge have no effect until the next main reset.
- R2: In big-endian order, byte size (`size_i`=2) delivers `lw_i[35:27]`, `[26:18]`, `[17:9]`, `[8:0]` in that sequence. Word size (`size_i`=1) delivers `lw_i[35:18]` and then `lw_i[17:0]`.
- R3: In little-endian order, byte size delivers `lw_i[8:0]`, `[17:9]`, `[26:18]`, `[35:27]` in that sequence. Word size delivers `lw_i[17:0]` and then `lw_i[35:18]`.
- R4: In long size (`size_i`=0, and also the unused code 3), `data_o` equals `lw_i`. Every transfer pops, whatever order was latched.
- R5: In the narrow sizes the piece sits in the low bits of `data_o`: bits [8:0] for a byte, bits [17:0] for a word. All bits above the piece are 0.
- R6: A transfer takes place in a cycle where `valid_o` and `rd_i` are both 1. `pop_o` is 1 only in the cycle of the transfer that takes the last piece of the current long word.
- R7: `valid_o` is 0 in each of these cases: while `lw_valid_i` is 0, while `rst_ni` is low, in the cycle before the order is sampled, and while `part_rst_ni` is 0. A `rd_i` in such a cycle neither advances the piece position nor pops.
- R8: A clock edge with `part_rst_ni` low returns the piece position to the first piece. The latched order is kept.
- R9: After a main reset, the first transfer delivers the first piece of the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main reset, active low, asynchronous |
| part_rst_ni | input | 1 | Partial reset, active low, synchronous; rewinds the piece position |
| order_sel_i | input | 1 | Order select, sampled once after the main reset (1 = big-endian) |
| size_i | input | 2 | Port size: 0 long, 1 word, 2 byte, 3 treated as long |
| lw_i | input | 36 | Head long word of the queue |
| lw_valid_i | input | 1 | Head long word is present |
| rd_i | input | 1 | Read request from the narrow port |
| data_o | output | 36 | Current piece, right-aligned and zero-extended |
| valid_o | output | 1 | A piece is available on `data_o` |
| pop_o | output | 1 | Removes the head long word from the queue |

## Verification
The bench builds the block with its default parameters: 9-bit lanes and four lanes, which gives a 36-bit long word. With these values a byte read walks all four lane positions, including both end lanes, in each order. A word read takes both halves. The bench also applies partial resets partway through a word, flips the order pin after it has been sampled, and repeats the main reset with the opposite order level.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_WORD = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } port_size_e;
endpackage

// File: rtl/unpack_order_latch.sv
module unpack_order_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic big_o,
  output logic armed_o
);
  logic armed_q, big_q;

  // sample the select pin once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      big_q   <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      big_q   <= sel_i;
    end
  end

  assign big_o   = big_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/unpack_piece_cnt.sv
module unpack_piece_cnt
  import unpack_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned CNT_W    = $clog2(NUM_LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  port_size_e       size_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NUM_LANES - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, last_cnt;

  always_comb begin
    case (size_i)
      SZ_WORD: last_cnt = LAST_WORD;
      SZ_BYTE: last_cnt = LAST_BYTE;
      default: last_cnt = '0;
    endcase
  end

  // >= keeps a size change mid-word from running past the end
  assign last_o = (cnt_q >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/unpack_lane_sel.sv
module unpack_lane_sel
  import unpack_pkg::*;
#(
  parameter int unsigned LANE_W    = 9,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned LONG_W   = LANE_W * NUM_LANES,
  localparam int unsigned HALF_W   = LONG_W / 2,
  localparam int unsigned CNT_W    = $clog2(NUM_LANES)
) (
  input  logic [LONG_W-1:0] lw_i,
  input  port_size_e        size_i,
  input  logic              big_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [LONG_W-1:0] data_o
);
  logic [LANE_W-1:0] lane [NUM_LANES];
  logic [HALF_W-1:0] half [2];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane[g] = lw_i[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = lw_i[h*HALF_W +: HALF_W];
  end

  logic [CNT_W-1:0] lane_idx;
  logic             half_idx;

  assign lane_idx = big_i ? (CNT_W'(NUM_LANES - 1) - cnt_i) : cnt_i;
  assign half_idx = big_i ? ~cnt_i[0] : cnt_i[0];

  always_comb begin
    data_o = '0;
    case (size_i)
      SZ_WORD: data_o[HALF_W-1:0] = half[half_idx];
      SZ_BYTE: data_o[LANE_W-1:0] = lane[lane_idx];
      default: data_o = lw_i;
    endcase
  end
endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker
  import unpack_pkg::*;
#(
  parameter int unsigned LANE_W    = 9,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned LONG_W   = LANE_W * NUM_LANES,
  localparam int unsigned CNT_W    = $clog2(NUM_LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              order_sel_i,
  input  logic [1:0]        size_i,
  input  logic [LONG_W-1:0] lw_i,
  input  logic              lw_valid_i,
  input  logic              rd_i,
  output logic [LONG_W-1:0] data_o,
  output logic              valid_o,
  output logic              pop_o
);
  port_size_e       size;
  logic             order_big_q, armed_q, last, adv;
  logic [CNT_W-1:0] cnt_q;

  assign size = port_size_e'(size_i);

  unpack_order_latch i_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (order_sel_i),
    .big_o   (order_big_q),
    .armed_o (armed_q)
  );

  assign valid_o = lw_valid_i & ~armed_q & part_rst_ni;
  assign adv     = valid_o & rd_i;
  assign pop_o   = adv & last;

  unpack_piece_cnt #(.NUM_LANES(NUM_LANES)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~part_rst_ni),
    .size_i (size),
    .adv_i  (adv),
    .cnt_o  (cnt_q),
    .last_o (last)
  );

  unpack_lane_sel #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_sel (
    .lw_i   (lw_i),
    .size_i (size),
    .big_i  (order_big_q),
    .cnt_i  (cnt_q),
    .data_o (data_o)
  );
endmodule

// File: rtl/unpack_chk.sv
module unpack_chk #(
  parameter int unsigned LANE_W    = 9,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned LONG_W   = LANE_W * NUM_LANES,
  localparam int unsigned CNT_W    = $clog2(NUM_LANES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              part_rst_ni,
  input logic [1:0]        size_i,
  input logic [LONG_W-1:0] lw_i,
  input logic              lw_valid_i,
  input logic              rd_i,
  input logic [LONG_W-1:0] data_o,
  input logic              valid_o,
  input logic              pop_o,
  input logic              order_big_q,
  input logic              armed_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R1
  order_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(order_big_q));
  // R6
  pop_needs_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (valid_o && rd_i));
  // R4
  long_pops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rd_i && (size_i == 2'd0 || size_i == 2'd3)) |-> (pop_o && data_o == lw_i));
  // R5
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd2) |-> (data_o[LONG_W-1:LANE_W] == '0));
  // R7
  valid_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lw_valid_i && part_rst_ni && !armed_q));
  // R7
  no_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(valid_o && rd_i) && part_rst_ni) |=> $stable(cnt_q));
  // R8
  part_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !part_rst_ni |=> (cnt_q == '0));
  // R2
  big_last_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && size_i == 2'd2 && order_big_q) |-> (data_o[LANE_W-1:0] == lw_i[LANE_W-1:0]));
  // R3
  little_last_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && size_i == 2'd2 && !order_big_q) |-> (data_o[LANE_W-1:0] == lw_i[LONG_W-1 -: LANE_W]));
endmodule

bind bus_unpacker unpack_chk #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_unpack_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .part_rst_ni (part_rst_ni),
  .size_i      (size_i),
  .lw_i        (lw_i),
  .lw_valid_i  (lw_valid_i),
  .rd_i        (rd_i),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .pop_o       (pop_o),
  .order_big_q (order_big_q),
  .armed_q     (armed_q),
  .cnt_q       (cnt_q)
);

// File: tb/test_bus_unpacker.sv
module test_bus_unpacker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, part_rst_ni = 1'b1, order_sel_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [35:0] lw_i = '0;
  logic        lw_valid_i = 1'b0, rd_i = 1'b0;
  logic [35:0] data_o;
  logic        valid_o, pop_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  bus_unpacker i_bus_unpacker (
    .clk_i(clk), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni), .order_sel_i(order_sel_i),
    .size_i(size_i), .lw_i(lw_i), .lw_valid_i(lw_valid_i), .rd_i(rd_i),
    .data_o(data_o), .valid_o(valid_o), .pop_o(pop_o)
  );

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_piece(input logic [35:0] lw, input logic [1:0] sz,
                                            input bit big, input int k);
    logic [35:0] r = '0;
    case (sz)
      2'd1: r[17:0] = (big ^ (k == 1)) ? lw[35:18] : lw[17:0];
      2'd2: r[8:0]  = big ? lw[35 - 9*k -: 9] : lw[9*k +: 9];
      default: r = lw;
    endcase
    return r;
  endfunction

  // called at a negedge; ends at the next negedge
  task automatic step_read(input logic [35:0] exp, input bit exp_pop, input string tag);
    rd_i = 1'b1;
    #1;
    chk({35'b0, valid_o}, 36'd1, {tag, " valid"});
    chk(data_o, exp, {tag, " data"});
    chk({35'b0, pop_o}, {35'b0, exp_pop}, {tag, " pop"});
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic read_word(input logic [35:0] lw, input logic [1:0] sz, input bit big,
                           input string tag);
    int n = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
    lw_i = lw;
    lw_valid_i = 1'b1;
    for (int k = 0; k < n; k++)
      step_read(exp_piece(lw, sz, big, k), k == n - 1, tag);
  endtask

  // R1 R7 R9: main reset, order sampled at the first edge after release
  task automatic do_reset(input bit big);
    @(negedge clk);
    rst_ni = 1'b0;
    lw_valid_i = 1'b1;
    rd_i = 1'b1;
    repeat (3) @(negedge clk);
    chk({34'b0, valid_o, pop_o}, 36'd0, "R7 in reset");
    order_sel_i = big;
    rst_ni = 1'b1;
    #1;
    chk({34'b0, valid_o, pop_o}, 36'd0, "R7 sampling cycle");
    @(negedge clk);
    rd_i = 1'b0;
    order_sel_i = ~big;  // later changes must be ignored (R1)
  endtask

  task automatic t_byte_big;
    do_reset(1'b1);
    size_i = 2'd2;
    read_word(36'h123456789, 2'd2, 1'b1, "R2 R9 byte big w0");
    read_word(36'hA5C3F0E1D, 2'd2, 1'b1, "R2 R5 byte big w1");
    order_sel_i = 1'b1;
    @(negedge clk);
    order_sel_i = 1'b0;
    read_word(36'h0FEDCBA98, 2'd2, 1'b1, "R1 order pin ignored");
  endtask

  task automatic t_word_big;
    size_i = 2'd1;
    read_word(36'h9ABCDEF01, 2'd1, 1'b1, "R2 R5 word big");
  endtask

  task automatic t_little;
    do_reset(1'b0);
    size_i = 2'd2;
    read_word(36'h123456789, 2'd2, 1'b0, "R3 R9 byte little");
    size_i = 2'd1;
    read_word(36'h3C3C5A5A1, 2'd1, 1'b0, "R3 R5 word little");
  endtask

  task automatic t_long;
    size_i = 2'd0;
    read_word(36'hDEADBEEF7, 2'd0, 1'b0, "R4 long");
    size_i = 2'd3;
    read_word(36'h876543210, 2'd3, 1'b0, "R4 code 3 long");
  endtask

  task automatic t_idle;
    size_i = 2'd2;
    lw_i = 36'h55AA33CC9;
    lw_valid_i = 1'b0;
    rd_i = 1'b1;
    #1;
    chk({34'b0, valid_o, pop_o}, 36'd0, "R7 empty ignores read");
    @(negedge clk);
    #1;
    chk({34'b0, valid_o, pop_o}, 36'd0, "R7 empty second cycle");
    rd_i = 1'b0;
    read_word(36'h55AA33CC9, 2'd2, 1'b0, "R7 no advance while empty");
  endtask

  task automatic t_part_reset;
    logic [35:0] w = 36'hF1E2D3C4B;
    size_i = 2'd2;
    lw_i = w;
    lw_valid_i = 1'b1;
    step_read(exp_piece(w, 2'd2, 1'b0, 0), 1'b0, "R8 pre piece0");
    step_read(exp_piece(w, 2'd2, 1'b0, 1), 1'b0, "R8 pre piece1");
    part_rst_ni = 1'b0;
    rd_i = 1'b1;
    #1;
    chk({34'b0, valid_o, pop_o}, 36'd0, "R7 R8 during partial reset");
    @(negedge clk);
    part_rst_ni = 1'b1;
    rd_i = 1'b0;
    read_word(w, 2'd2, 1'b0, "R8 restart at first piece, order kept");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_byte_big();
    t_word_big();
    t_long();
    t_little();
    t_idle();
    t_part_reset();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule